// File: doc/BRIEF.md
# 10BASE-T Link Integrity Controller

This block decides whether a 10 Mb/s twisted-pair port has a live partner, and it keeps the partner informed that this end is alive. A timer watches receive activity. Both received packets and received link pulses count as activity. If the timer runs out while the link is up, the controller drops `link_ok`. The MAC side uses `link_ok` to hold off packet transmission. Recovery is deliberately asymmetric. One received packet brings the link back, and that packet is not passed on. Otherwise the link needs two link pulses whose spacing lands inside a bounded window.

Independently of the link state, a pulse timer asks the line driver for a one-bit-time link pulse roughly every 16 ms whenever no frame is being sent. The timer is held cleared during transmission and restarts when a frame's end-of-frame sequence completes. All timing is counted in pulses of a single `tick` strobe, nominally one per millisecond. The block clock is the 100 ns bit clock, so one clock cycle is one bit time. A simulation can therefore scale time simply by ticking faster.

Top module: `lnk_integrity_ctrl`

## Requirements
- R1: After reset `link_ok`, `led_on`, `lp_req` and `rx_pkt_fwd` are all 0, and the controller is in the link-failed state.
- R2: While the link is up, the LOSS_TICKS-th tick (default 60) after the last received packet or link pulse drops `link_ok` on the following clock cycle. Any earlier tick leaves it up.
- R3: While the link is down, a `rx_packet` strobe raises `link_ok` one cycle later, and `rx_pkt_fwd` stays 0 for that packet. While the link is up, each `rx_packet` strobe produces a one-cycle `rx_pkt_fwd` pulse one cycle later.
- R4: While the link is down, a link pulse raises `link_ok` one cycle later when a pending first pulse precedes it by more than MIN_GAP ticks (default 6) and no more than MAX_GAP ticks (default 50).
- R5: A link pulse that comes MIN_GAP ticks or fewer after the pending one replaces it as the new first pulse. The (MAX_GAP+1)-th tick after a pending pulse discards that pulse.
- R6: With `tx_active` low, `lp_req` goes high for exactly one cycle, in the cycle after every PULSE_TICKS-th tick (default 16) counted since the last emitted pulse, reset or restart.
- R7: Link pulses are requested both while the link is down and while it is up.
- R8: No `lp_req` is produced while `tx_active` is high, and the pulse timer is held cleared during that time.
- R9: A `tx_eof` strobe restarts the pulse timer, so the next `lp_req` follows the PULSE_TICKS-th tick after it.
- R10: `led_on` equals `link_ok` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock (one cycle is one bit time) |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle time-base strobe (nominally 1 ms) |
| rx_link_pulse | input | 1 | One-cycle strobe per received link pulse |
| rx_packet | input | 1 | One-cycle strobe per received packet |
| tx_active | input | 1 | High while a frame is being transmitted |
| tx_eof | input | 1 | One-cycle strobe when a transmitted frame's end-of-frame sequence completes |
| link_ok | output | 1 | Link up; gates packet transmission |
| lp_req | output | 1 | One-cycle request for a transmitted link pulse |
| led_on | output | 1 | Link LED drive, high while the link is up |
| rx_pkt_fwd | output | 1 | One-cycle strobe for a packet accepted while the link was up |

## Verification
Every result of this block is a registered output. `link_ok`, `lp_req` and `rx_pkt_fwd` therefore change exactly one clock cycle after the strobe that causes them: a tick, a link pulse or a packet. The bench drives each strobe for one cycle from a falling edge and samples at the next falling edge, which is half a cycle after the updating rising edge. Expected link pulses are predicted by a tick-counting model in the driver and queued with the cycle number in which they are due. The monitor pops an entry only when `lp_req` is seen high, requires the cycle number to match, and flags any pulse that nobody predicted as well as any prediction left over at the end.

// File: rtl/lnk_integrity_pkg.sv
package lnk_integrity_pkg;

    typedef enum logic {
        LINK_DOWN = 1'b0,
        LINK_UP   = 1'b1
    } link_state_e;

    // receive-side events seen in one clock cycle
    typedef struct packed {
        logic tick;
        logic lp;
        logic pkt;
    } rx_evt_t;

    // bits needed to hold values 0..n
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/lnk_loss_timer.sv
module lnk_loss_timer
    import lnk_integrity_pkg::*;
#(
    parameter int unsigned LOSS_TICKS = 60
) (
    input  logic    clk,
    input  logic    rst,
    input  rx_evt_t ev,
    output logic    expire
);
    localparam int unsigned LW = cnt_width(LOSS_TICKS);
    localparam logic [LW-1:0] LAST = LW'(LOSS_TICKS - 1);

    logic [LW-1:0] idle_cnt;
    logic          activity;

    assign activity = ev.lp | ev.pkt;
    assign expire   = ev.tick & ~activity & (idle_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || activity || expire) begin
            idle_cnt <= '0;
        end else if (ev.tick) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lnk_pair_qual.sv
module lnk_pair_qual
    import lnk_integrity_pkg::*;
#(
    parameter int unsigned MIN_GAP = 6,
    parameter int unsigned MAX_GAP = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic lp,
    input  logic tick,
    output logic qualify
);
    localparam int unsigned GW = cnt_width(MAX_GAP);
    localparam logic [GW-1:0] GMIN = GW'(MIN_GAP);
    localparam logic [GW-1:0] GMAX = GW'(MAX_GAP);

    logic          pending;
    logic [GW-1:0] gap;

    assign qualify = armed & lp & pending & (gap > GMIN) & (gap <= GMAX);

    always_ff @(posedge clk) begin
        if (rst || !armed) begin
            pending <= 1'b0;
            gap     <= '0;
        end else if (lp) begin
            // a qualifying pair consumes the pending pulse; any other pulse becomes the new first
            pending <= ~qualify;
            gap     <= '0;
        end else if (tick && pending) begin
            if (gap == GMAX) begin
                pending <= 1'b0;
                gap     <= '0;
            end else begin
                gap <= gap + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lnk_pulse_gen.sv
module lnk_pulse_gen
    import lnk_integrity_pkg::*;
#(
    parameter int unsigned PULSE_TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic tx_active,
    input  logic tx_eof,
    output logic lp_req
);
    localparam int unsigned PW = cnt_width(PULSE_TICKS);
    localparam logic [PW-1:0] LAST = PW'(PULSE_TICKS - 1);

    logic [PW-1:0] cnt;
    logic          fire;

    assign fire = tick & ~tx_active & ~tx_eof & (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            lp_req <= 1'b0;
        end else begin
            lp_req <= fire;
            if (tx_active || tx_eof || fire) begin
                cnt <= '0;
            end else if (tick) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lnk_integrity_ctrl.sv
module lnk_integrity_ctrl
    import lnk_integrity_pkg::*;
#(
    parameter int unsigned LOSS_TICKS  = 60,
    parameter int unsigned MIN_GAP     = 6,
    parameter int unsigned MAX_GAP     = 50,
    parameter int unsigned PULSE_TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rx_link_pulse,
    input  logic rx_packet,
    input  logic tx_active,
    input  logic tx_eof,
    output logic link_ok,
    output logic lp_req,
    output logic led_on,
    output logic rx_pkt_fwd
);
    link_state_e state;
    rx_evt_t     ev;
    logic        expire;
    logic        qualify;
    logic        fwd_q;

    assign ev = '{tick: tick, lp: rx_link_pulse, pkt: rx_packet};

    lnk_loss_timer #(.LOSS_TICKS(LOSS_TICKS)) u_loss (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .expire (expire)
    );

    lnk_pair_qual #(.MIN_GAP(MIN_GAP), .MAX_GAP(MAX_GAP)) u_pair (
        .clk     (clk),
        .rst     (rst),
        .armed   (state == LINK_DOWN),
        .lp      (rx_link_pulse),
        .tick    (tick),
        .qualify (qualify)
    );

    lnk_pulse_gen #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .tx_active (tx_active),
        .tx_eof    (tx_eof),
        .lp_req    (lp_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LINK_DOWN;
            fwd_q <= 1'b0;
        end else begin
            // a recovering packet is swallowed: forwarding uses the state before this edge
            fwd_q <= rx_packet & (state == LINK_UP);
            unique case (state)
                LINK_DOWN: if (rx_packet || qualify) state <= LINK_UP;
                LINK_UP:   if (expire)               state <= LINK_DOWN;
                default:   state <= LINK_DOWN;
            endcase
        end
    end

    assign link_ok    = (state == LINK_UP);
    assign led_on     = link_ok;
    assign rx_pkt_fwd = fwd_q;
endmodule

// File: rtl/lnk_integrity_chk.sv
module lnk_integrity_chk (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic rx_link_pulse,
    input logic rx_packet,
    input logic tx_active,
    input logic tx_eof,
    input logic link_ok,
    input logic lp_req,
    input logic led_on,
    input logic rx_pkt_fwd
);
    // link may only drop on a tick that carried no receive activity
    p_drop_on_idle_tick_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(link_ok) |-> ($past(tick) && !$past(rx_link_pulse) && !$past(rx_packet)));

    // forwarded packet implies a packet strobe seen while the link was up
    p_fwd_only_when_up_r3: assert property (@(posedge clk) disable iff (rst)
        rx_pkt_fwd |-> ($past(rx_packet) && $past(link_ok)));

    // link may only rise right after a packet or a link pulse
    p_rise_needs_event_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(link_ok) |-> ($past(rx_packet) || $past(rx_link_pulse)));

    // pulse request lasts a single cycle
    p_pulse_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        lp_req |=> !lp_req);

    // no pulse request caused by a cycle with transmit activity or no tick
    p_no_pulse_in_tx_r8: assert property (@(posedge clk) disable iff (rst)
        lp_req |-> ($past(tick) && !$past(tx_active) && !$past(tx_eof)));

    // LED mirrors link state
    p_led_follows_r10: assert property (@(posedge clk) disable iff (rst)
        led_on == link_ok);
endmodule

bind lnk_integrity_ctrl lnk_integrity_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .tick          (tick),
    .rx_link_pulse (rx_link_pulse),
    .rx_packet     (rx_packet),
    .tx_active     (tx_active),
    .tx_eof        (tx_eof),
    .link_ok       (link_ok),
    .lp_req        (lp_req),
    .led_on        (led_on),
    .rx_pkt_fwd    (rx_pkt_fwd)
);

// File: tb/lnk_integrity_ctrl_tb.sv
`timescale 1ns/1ps
module lnk_integrity_ctrl_tb;
    localparam int LOSS  = 60;
    localparam int MINV  = 6;
    localparam int MAXV  = 50;
    localparam int PULSE = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0, rx_link_pulse = 1'b0, rx_packet = 1'b0;
    logic tx_active = 1'b0, tx_eof = 1'b0;
    logic link_ok, lp_req, led_on, rx_pkt_fwd;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int mcnt = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lnk_integrity_ctrl u_dut (
        .clk (clk), .rst (rst), .tick (tick),
        .rx_link_pulse (rx_link_pulse), .rx_packet (rx_packet),
        .tx_active (tx_active), .tx_eof (tx_eof),
        .link_ok (link_ok), .lp_req (lp_req), .led_on (led_on),
        .rx_pkt_fwd (rx_pkt_fwd)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // monitor: every observed pulse request must match the next predicted cycle (R6, R7, R8, R9)
    always @(negedge clk) begin
        if (!rst && !done && lp_req) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R8 unexpected lp_req actual=cycle %0d expected=none", cyc);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e != cyc) begin
                    errors++;
                    $display("FAIL R6 lp_req actual=cycle %0d expected=cycle %0d", cyc, e);
                end
            end
        end
    end

    // driver: one tick, with the pulse model pushing the due cycle
    task automatic do_tick();
        tick = 1'b1;
        if (tx_active) begin
            mcnt = 0;
        end else if (mcnt == PULSE - 1) begin
            exp_q.push_back(cyc + 1);
            mcnt = 0;
        end else begin
            mcnt++;
        end
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) do_tick();
    endtask

    task automatic lp_in();
        rx_link_pulse = 1'b1;
        @(negedge clk);
        rx_link_pulse = 1'b0;
    endtask

    task automatic pkt_in();
        rx_packet = 1'b1;
        @(negedge clk);
        rx_packet = 1'b0;
    endtask

    task automatic eof_in();
        tx_eof = 1'b1;
        mcnt = 0;
        @(negedge clk);
        tx_eof = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 link_ok", link_ok, 1'b0);
        check("R1 led_on", led_on, 1'b0);
        check("R1 lp_req", lp_req, 1'b0);
        check("R1 rx_pkt_fwd", rx_pkt_fwd, 1'b0);

        // R6/R7 pulses while down
        ticks(PULSE + 5);

        // R8 transmit suppresses pulses and clears the timer
        tx_active = 1'b1;
        ticks(20);
        tx_active = 1'b0;
        eof_in();
        // R9 restart mid-count
        ticks(10);
        eof_in();
        ticks(PULSE);

        // R5 too-early pulse becomes the new first
        lp_in();
        ticks(3);
        lp_in();
        ticks(4);
        lp_in();
        check("R5 early pair ignored", link_ok, 1'b0);
        ticks(MINV + 1);
        lp_in();
        check("R4 pair in window", link_ok, 1'b1);
        check("R10 led up", led_on, 1'b1);

        // R2 loss timer
        ticks(LOSS - 1);
        check("R2 still up before limit", link_ok, 1'b1);
        ticks(1);
        check("R2 down at limit", link_ok, 1'b0);
        check("R10 led down", led_on, 1'b0);

        // R4 lower boundary: gap equal to MIN does not qualify
        lp_in();
        ticks(MINV);
        lp_in();
        check("R4 gap at min rejected", link_ok, 1'b0);
        ticks(MINV + 1);
        lp_in();
        check("R4 gap min+1 accepted", link_ok, 1'b1);
        ticks(LOSS);
        check("R2 down again", link_ok, 1'b0);

        // R4 upper boundary: gap equal to MAX qualifies
        lp_in();
        ticks(MAXV);
        lp_in();
        check("R4 gap at max accepted", link_ok, 1'b1);
        ticks(LOSS);
        check("R2 down third", link_ok, 1'b0);

        // R5 gap over MAX discards the pending pulse
        lp_in();
        ticks(MAXV + 1);
        lp_in();
        check("R5 gap over max rejected", link_ok, 1'b0);
        ticks(MINV + 1);
        lp_in();
        check("R5 late pulse acted as new first", link_ok, 1'b1);
        ticks(LOSS);
        check("R2 down before packet test", link_ok, 1'b0);

        // R3 packet recovery, recovering packet swallowed
        pkt_in();
        check("R3 packet restores link", link_ok, 1'b1);
        check("R3 recovering packet not forwarded", rx_pkt_fwd, 1'b0);
        @(negedge clk);
        pkt_in();
        check("R3 packet forwarded while up", rx_pkt_fwd, 1'b1);
        @(negedge clk);
        check("R3 forward is one cycle", rx_pkt_fwd, 1'b0);
        ticks(PULSE);

        @(negedge clk);
        done = 1'b1;
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R6 missing lp_req actual=%0d pending expected=0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule